// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Interval Timer

This block keeps the wall-clock date and time inside a chip. A one-cycle enable, strobed once per second by the surrounding logic, advances a seconds, minutes, hours, day-of-week, day, month and two-digit year chain. Month lengths, including February in leap years, are resolved in a single step. Any second can roll all the way up into a new year.

The host can write a complete new time and date at any moment. The count keeps running from the written value and never stops. A date/time alarm compares minute, hour, day, month and year against programmed values. Each field has its own enable bit, so the alarm can follow any subset of them. A separate interval timer counts one-second ticks. It raises a pulse once after a programmed delay, or again at the end of every period.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 0, day 1, month 1, year 0, and both interrupt outputs are low.
- R2: Each tick advances seconds by one. Seconds and minutes wrap from 59 to 0 and carry upward. Hours wrap from 23 to 0. Without a tick or a load, every time output holds its value.
- R3: Day of week goes up by one exactly when the hour rolls from 23 to 0, and wraps from 6 to 0.
- R4: The day wraps to 1 and the month advances after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11.
- R5: February ends after day 29 when the year is a multiple of 4 (00 included), and after day 28 in every other year.
- R6: After 31 December the month and day return to 1. The year goes up by one and wraps from 99 to 00.
- R7: A load writes all seven time fields in one cycle, and the count then continues from the written value. When a load and a tick fall in the same cycle, the loaded value appears unchanged and that tick is lost.
- R8: The alarm output is a one-cycle pulse in the cycle where a tick has just brought seconds to 00 and every enabled field matches. Mask bit 0 enables minute, bit 1 hour, bit 2 day, bit 3 month and bit 4 year. An all-zero mask never fires. A load never fires the alarm.
- R9: With the repeat flag clear, the timer pulses once, on the Nth tick after a write of period N with the run bit set, and then stops.
- R10: With the repeat flag set, the timer pulses on every Nth tick.
- R11: A timer write discards a tick that falls in the same cycle. A write of period 0 or with the run bit clear stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-second advance enable |
| ld_en | input | 1 | Write all time fields this cycle |
| ld_sec | input | 6 | Seconds to load (0-59) |
| ld_min | input | 6 | Minutes to load (0-59) |
| ld_hour | input | 5 | Hours to load (0-23) |
| ld_dow | input | 3 | Day of week to load (0-6) |
| ld_day | input | 5 | Day of month to load (valid for month) |
| ld_mon | input | 4 | Month to load (1-12) |
| ld_year | input | 7 | Year to load (0-99) |
| alm_wr | input | 1 | Write the alarm values and mask |
| alm_min | input | 6 | Alarm minute |
| alm_hour | input | 5 | Alarm hour |
| alm_day | input | 5 | Alarm day |
| alm_mon | input | 4 | Alarm month |
| alm_year | input | 7 | Alarm year |
| alm_mask | input | 5 | Per-field alarm enables |
| tmr_wr | input | 1 | Write the interval timer setup |
| tmr_period | input | TMR_W | Interval in ticks |
| tmr_repeat | input | 1 | 1 selects periodic, 0 selects one-shot |
| tmr_go | input | 1 | Run bit written with the setup |
| cur_sec | output | 6 | Current seconds |
| cur_min | output | 6 | Current minutes |
| cur_hour | output | 5 | Current hours |
| cur_dow | output | 3 | Current day of week |
| cur_day | output | 5 | Current day of month |
| cur_mon | output | 4 | Current month |
| cur_year | output | 7 | Current year |
| alarm_irq | output | 1 | Alarm pulse |
| timer_irq | output | 1 | Interval timer pulse |

## Verification
A host time write and a one-second tick can land in the same cycle. So can a timer setup write and a tick. The bench raises the write strobes while the tick is held high, both on directed edges such as a load onto second 00 under an armed alarm and during a long random phase. A reference model computes the expected time and pulse for every cycle, with the write winning and the tick dropped. Every output is compared with that model each cycle, and pulse counts are checked over each directed window.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] mon;
      logic [4:0] day;
      logic [2:0] dow;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } cal_time_t;

   localparam logic [5:0] SEC_LAST  = 6'd59;
   localparam logic [5:0] MIN_LAST  = 6'd59;
   localparam logic [4:0] HOUR_LAST = 5'd23;
   localparam logic [2:0] DOW_LAST  = 3'd6;
   localparam logic [3:0] MON_LAST  = 4'd12;
   localparam logic [6:0] YEAR_LAST = 7'd99;

   // alarm field slots; the mask bit order follows these indices
   localparam int AF_MIN  = 0;
   localparam int AF_HOUR = 1;
   localparam int AF_DAY  = 2;
   localparam int AF_MON  = 3;
   localparam int AF_YEAR = 4;
   localparam int AF_N    = 5;
   localparam int AF_W    = 7;

   localparam cal_time_t TIME_RESET = '{year: 7'd0, mon: 4'd1, day: 5'd1,
                                        dow: 3'd0, hour: 5'd0, min: 6'd0,
                                        sec: 6'd0};

   function automatic logic [4:0] month_days(logic [3:0] mon, logic [6:0] year);
      logic [4:0] n;
      case (mon)
         4'd2:                      n = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
         default:                   n = 5'd31;
      endcase
      return n;
   endfunction

   // one-second step with the full carry chain up to the year
   function automatic cal_time_t cal_advance(cal_time_t t);
      cal_time_t n;
      n = t;
      if (t.sec != SEC_LAST) begin
         n.sec = t.sec + 6'd1;
      end else begin
         n.sec = 6'd0;
         if (t.min != MIN_LAST) begin
            n.min = t.min + 6'd1;
         end else begin
            n.min = 6'd0;
            if (t.hour != HOUR_LAST) begin
               n.hour = t.hour + 5'd1;
            end else begin
               n.hour = 5'd0;
               n.dow  = (t.dow == DOW_LAST) ? 3'd0 : t.dow + 3'd1;
               if (t.day != month_days(t.mon, t.year)) begin
                  n.day = t.day + 5'd1;
               end else begin
                  n.day = 5'd1;
                  if (t.mon != MON_LAST) begin
                     n.mon = t.mon + 4'd1;
                  end else begin
                     n.mon  = 4'd1;
                     n.year = (t.year == YEAR_LAST) ? 7'd0 : t.year + 7'd1;
                  end
               end
            end
         end
      end
      return n;
   endfunction
endpackage

// File: rtl/cal_counter.sv
module cal_counter
   import cal_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      ld_en,
   input  cal_time_t ld_time,
   output cal_time_t cur,
   output logic      step_q
);
   timeunit 1ns;
   timeprecision 100ps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= TIME_RESET;
         step_q <= 1'b0;
      end else begin
         // a load wins over a tick in the same cycle
         if (ld_en)
            cur <= ld_time;
         else if (tick)
            cur <= cal_advance(cur);
         step_q <= tick & ~ld_en;
      end
   end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
   parameter int N = 5,
   parameter int W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [N-1:0][W-1:0] wr_val,
   input  logic [N-1:0]       wr_mask,
   input  logic               step,
   input  logic               sec_zero,
   input  logic [N-1:0][W-1:0] cur_val,
   output logic               irq
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [N-1:0][W-1:0] val_q;
   logic [N-1:0]        mask_q;
   logic [N-1:0]        hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         mask_q <= '0;
      end else if (wr) begin
         val_q  <= wr_val;
         mask_q <= wr_mask;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = ~mask_q[i] | (val_q[i] == cur_val[i]);
   end

   // step marks the cycle right after a counted tick
   assign irq = step & sec_zero & (|mask_q) & (&hit);
endmodule

// File: rtl/cal_interval.sv
module cal_interval #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr,
   input  logic [TMR_W-1:0] wr_period,
   input  logic             wr_repeat,
   input  logic             wr_go,
   output logic             irq
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   logic [TMR_W-1:0] per_q, cnt_q;
   logic             rep_q, run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         cnt_q <= '0;
         rep_q <= 1'b0;
         run_q <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (wr) begin
            per_q <= wr_period;
            cnt_q <= wr_period;
            rep_q <= wr_repeat;
            run_q <= wr_go & (wr_period != '0);
         end else if (tick && run_q) begin
            if (cnt_q == ONE) begin
               irq <= 1'b1;
               if (rep_q)
                  cnt_q <= per_q;
               else
                  run_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
   import cal_rtc_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1hz,
   input  logic             ld_en,
   input  logic [5:0]       ld_sec,
   input  logic [5:0]       ld_min,
   input  logic [4:0]       ld_hour,
   input  logic [2:0]       ld_dow,
   input  logic [4:0]       ld_day,
   input  logic [3:0]       ld_mon,
   input  logic [6:0]       ld_year,
   input  logic             alm_wr,
   input  logic [5:0]       alm_min,
   input  logic [4:0]       alm_hour,
   input  logic [4:0]       alm_day,
   input  logic [3:0]       alm_mon,
   input  logic [6:0]       alm_year,
   input  logic [4:0]       alm_mask,
   input  logic             tmr_wr,
   input  logic [TMR_W-1:0] tmr_period,
   input  logic             tmr_repeat,
   input  logic             tmr_go,
   output logic [5:0]       cur_sec,
   output logic [5:0]       cur_min,
   output logic [4:0]       cur_hour,
   output logic [2:0]       cur_dow,
   output logic [4:0]       cur_day,
   output logic [3:0]       cur_mon,
   output logic [6:0]       cur_year,
   output logic             alarm_irq,
   output logic             timer_irq
);
   timeunit 1ns;
   timeprecision 100ps;

   if (TMR_W < 1 || TMR_W > 32) begin : g_bad_tmr_w
      $error("cal_rtc: TMR_W must lie in 1..32");
   end

   cal_time_t                    ld_time, now;
   logic                         step_q;
   logic [AF_N-1:0][AF_W-1:0]    alm_val, now_val;

   assign ld_time = '{year: ld_year, mon: ld_mon, day: ld_day, dow: ld_dow,
                      hour: ld_hour, min: ld_min, sec: ld_sec};

   cal_counter u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1hz),
      .ld_en   (ld_en),
      .ld_time (ld_time),
      .cur     (now),
      .step_q  (step_q)
   );

   assign alm_val[AF_MIN]  = {1'b0, alm_min};
   assign alm_val[AF_HOUR] = {2'b0, alm_hour};
   assign alm_val[AF_DAY]  = {2'b0, alm_day};
   assign alm_val[AF_MON]  = {3'b0, alm_mon};
   assign alm_val[AF_YEAR] = alm_year;

   assign now_val[AF_MIN]  = {1'b0, now.min};
   assign now_val[AF_HOUR] = {2'b0, now.hour};
   assign now_val[AF_DAY]  = {2'b0, now.day};
   assign now_val[AF_MON]  = {3'b0, now.mon};
   assign now_val[AF_YEAR] = now.year;

   cal_alarm #(.N(AF_N), .W(AF_W)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (alm_wr),
      .wr_val   (alm_val),
      .wr_mask  (alm_mask),
      .step     (step_q),
      .sec_zero (now.sec == 6'd0),
      .cur_val  (now_val),
      .irq      (alarm_irq)
   );

   cal_interval #(.TMR_W(TMR_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1hz),
      .wr        (tmr_wr),
      .wr_period (tmr_period),
      .wr_repeat (tmr_repeat),
      .wr_go     (tmr_go),
      .irq       (timer_irq)
   );

   assign cur_sec  = now.sec;
   assign cur_min  = now.min;
   assign cur_hour = now.hour;
   assign cur_dow  = now.dow;
   assign cur_day  = now.day;
   assign cur_mon  = now.mon;
   assign cur_year = now.year;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk #(
   parameter int TMR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_1hz,
   input logic             ld_en,
   input logic [5:0]       ld_sec,
   input logic [5:0]       ld_min,
   input logic [4:0]       ld_hour,
   input logic [2:0]       ld_dow,
   input logic [4:0]       ld_day,
   input logic [3:0]       ld_mon,
   input logic [6:0]       ld_year,
   input logic             tmr_wr,
   input logic [5:0]       cur_sec,
   input logic [5:0]       cur_min,
   input logic [4:0]       cur_hour,
   input logic [2:0]       cur_dow,
   input logic [4:0]       cur_day,
   input logic [3:0]       cur_mon,
   input logic [6:0]       cur_year,
   input logic             alarm_irq,
   input logic             timer_irq
);
   timeunit 1ns;
   timeprecision 100ps;

   // R2
   a_r2_field_limits: assert property (@(posedge clk) disable iff (!rst_n)
      cur_sec <= 6'd59 && cur_min <= 6'd59 && cur_hour <= 5'd23);

   // R2
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1hz && !ld_en) |=> $stable({cur_year, cur_mon, cur_day, cur_dow,
                                          cur_hour, cur_min, cur_sec}));

   // R3
   a_r3_dow_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cur_dow <= 3'd6);

   // R3
   a_r3_dow_midnight: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_dow != $past(cur_dow) && !$past(ld_en))
         |-> (cur_hour == 5'd0 && cur_min == 6'd0 && cur_sec == 6'd0));

   // R4
   a_r4_date_limits: assert property (@(posedge clk) disable iff (!rst_n)
      cur_day >= 5'd1 && cur_day <= 5'd31 && cur_mon >= 4'd1 && cur_mon <= 4'd12);

   // R6
   a_r6_year_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cur_year <= 7'd99);

   // R7
   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (cur_sec == $past(ld_sec) && cur_min == $past(ld_min) &&
                 cur_hour == $past(ld_hour) && cur_dow == $past(ld_dow) &&
                 cur_day == $past(ld_day) && cur_mon == $past(ld_mon) &&
                 cur_year == $past(ld_year)));

   // R8
   a_r8_alarm_on_minute: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> (cur_sec == 6'd0 && $past(tick_1hz) && !$past(ld_en)));

   // R8
   a_r8_alarm_single: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |=> !alarm_irq);

   // R11
   a_r11_timer_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      timer_irq |-> ($past(tick_1hz) && !$past(tmr_wr)));
endmodule

bind cal_rtc cal_rtc_chk #(.TMR_W(TMR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_1hz  (tick_1hz),
   .ld_en     (ld_en),
   .ld_sec    (ld_sec),
   .ld_min    (ld_min),
   .ld_hour   (ld_hour),
   .ld_dow    (ld_dow),
   .ld_day    (ld_day),
   .ld_mon    (ld_mon),
   .ld_year   (ld_year),
   .tmr_wr    (tmr_wr),
   .cur_sec   (cur_sec),
   .cur_min   (cur_min),
   .cur_hour  (cur_hour),
   .cur_dow   (cur_dow),
   .cur_day   (cur_day),
   .cur_mon   (cur_mon),
   .cur_year  (cur_year),
   .alarm_irq (alarm_irq),
   .timer_irq (timer_irq)
);

// File: tb/cal_rtc_test.sv
module cal_rtc_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          tick_1hz = 0, ld_en = 0, alm_wr = 0, tmr_wr = 0;
   logic [5:0]    ld_sec = 0, ld_min = 0, alm_min = 0;
   logic [4:0]    ld_hour = 0, ld_day = 1, alm_hour = 0, alm_day = 0, alm_mask = 0;
   logic [2:0]    ld_dow = 0;
   logic [3:0]    ld_mon = 1, alm_mon = 0;
   logic [6:0]    ld_year = 0, alm_year = 0;
   logic [TW-1:0] tmr_period = 0;
   logic          tmr_repeat = 0, tmr_go = 0;
   logic [5:0]    cur_sec, cur_min;
   logic [4:0]    cur_hour, cur_day;
   logic [2:0]    cur_dow;
   logic [3:0]    cur_mon;
   logic [6:0]    cur_year;
   logic          alarm_irq, timer_irq;

   cal_rtc #(.TMR_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .ld_en(ld_en),
      .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
      .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
      .alm_wr(alm_wr), .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
      .alm_mon(alm_mon), .alm_year(alm_year), .alm_mask(alm_mask),
      .tmr_wr(tmr_wr), .tmr_period(tmr_period), .tmr_repeat(tmr_repeat),
      .tmr_go(tmr_go),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
      .cur_day(cur_day), .cur_mon(cur_mon), .cur_year(cur_year),
      .alarm_irq(alarm_irq), .timer_irq(timer_irq)
   );

   int vectors = 0, miscompares = 0;
   bit done = 0;
   string cur_req = "R1";
   int a_seen = 0, t_seen = 0;

   // reference model state
   int m_sec = 0, m_min = 0, m_hour = 0, m_dow = 0, m_day = 1, m_mon = 1, m_year = 0;
   int r_min = 0, r_hour = 0, r_day = 0, r_mon = 0, r_year = 0, r_mask = 0;
   int t_per = 0, t_cnt = 0, t_rep = 0, t_run = 0;
   int e_airq = 0, e_tirq = 0;

   function automatic int bdim(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic cmp(string tag, string nm, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
      end
   endtask

   task automatic model_edge();
      bit stepped;
      if (alm_wr) begin
         r_min = alm_min; r_hour = alm_hour; r_day = alm_day;
         r_mon = alm_mon; r_year = alm_year; r_mask = alm_mask;
      end
      stepped = 0;
      if (ld_en) begin
         m_sec = ld_sec; m_min = ld_min; m_hour = ld_hour; m_dow = ld_dow;
         m_day = ld_day; m_mon = ld_mon; m_year = ld_year;
      end else if (tick_1hz) begin
         stepped = 1;
         m_sec++;
         if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
               m_min = 0; m_hour++;
               if (m_hour == 24) begin
                  m_hour = 0; m_dow = (m_dow + 1) % 7; m_day++;
                  if (m_day > bdim(m_mon, m_year)) begin
                     m_day = 1; m_mon++;
                     if (m_mon > 12) begin
                        m_mon = 1; m_year = (m_year + 1) % 100;
                     end
                  end
               end
            end
         end
      end
      e_airq = (stepped && m_sec == 0 && r_mask != 0 &&
                (!r_mask[0] || r_min == m_min) && (!r_mask[1] || r_hour == m_hour) &&
                (!r_mask[2] || r_day == m_day) && (!r_mask[3] || r_mon == m_mon) &&
                (!r_mask[4] || r_year == m_year)) ? 1 : 0;
      e_tirq = 0;
      if (tmr_wr) begin
         t_per = tmr_period; t_cnt = t_per; t_rep = tmr_repeat;
         t_run = (tmr_go && t_per != 0) ? 1 : 0;
      end else if (tick_1hz && t_run != 0) begin
         if (t_cnt == 1) begin
            e_tirq = 1;
            if (t_rep != 0) t_cnt = t_per; else t_run = 0;
         end else begin
            t_cnt--;
         end
      end
   endtask

   task automatic check_all();
      cmp({cur_req, "/R2"}, "sec",  cur_sec,  m_sec);
      cmp({cur_req, "/R2"}, "min",  cur_min,  m_min);
      cmp({cur_req, "/R2"}, "hour", cur_hour, m_hour);
      cmp({cur_req, "/R3"}, "dow",  cur_dow,  m_dow);
      cmp({cur_req, "/R4"}, "day",  cur_day,  m_day);
      cmp({cur_req, "/R4"}, "mon",  cur_mon,  m_mon);
      cmp({cur_req, "/R6"}, "year", cur_year, m_year);
      cmp({cur_req, "/R8"}, "alarm_irq", alarm_irq, e_airq);
      cmp({cur_req, "/R9"}, "timer_irq", timer_irq, e_tirq);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all();
      if (alarm_irq) a_seen++;
      if (timer_irq) t_seen++;
   endtask

   task automatic set_load(int y, int mo, int d, int w, int h, int mi, int s);
      ld_year = 7'(y); ld_mon = 4'(mo); ld_day = 5'(d); ld_dow = 3'(w);
      ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s); ld_en = 1;
   endtask

   task automatic do_load(int y, int mo, int d, int w, int h, int mi, int s);
      set_load(y, mo, d, w, h, mi, s);
      cyc();
      ld_en = 0;
   endtask

   task automatic ticks(int n);
      tick_1hz = 1;
      repeat (n) cyc();
      tick_1hz = 0;
   endtask

   task automatic set_alarm(int y, int mo, int d, int h, int mi, int mask);
      alm_year = 7'(y); alm_mon = 4'(mo); alm_day = 5'(d);
      alm_hour = 5'(h); alm_min = 6'(mi); alm_mask = 5'(mask); alm_wr = 1;
      cyc();
      alm_wr = 0;
   endtask

   task automatic set_timer(int p, int rep, int go);
      tmr_period = TW'(p); tmr_repeat = rep[0]; tmr_go = go[0]; tmr_wr = 1;
      cyc();
      tmr_wr = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: state during and right after reset
      repeat (3) @(negedge clk);
      check_all();
      rst_n = 1;
      cyc();

      // R2: second, minute and hour wraps
      cur_req = "R2";
      do_load(10, 5, 10, 2, 0, 0, 57);
      ticks(4);
      do_load(10, 5, 10, 2, 10, 59, 59);
      ticks(1);
      cmp("R2", "hour after carry", cur_hour, 11);
      repeat (3) cyc();

      // R3: day of week advance and wrap
      cur_req = "R3";
      do_load(10, 5, 10, 6, 23, 59, 59);
      ticks(2);
      cmp("R3", "dow wrap", cur_dow, 0);

      // R4: 30- and 31-day months
      cur_req = "R4";
      do_load(21, 4, 30, 1, 23, 59, 59);
      ticks(1);
      cmp("R4", "april end month", cur_mon, 5);
      do_load(21, 1, 31, 1, 23, 59, 59);
      ticks(1);
      do_load(21, 8, 30, 1, 23, 59, 59);
      ticks(1);
      cmp("R4", "august 31st", cur_day, 31);

      // R5: February in leap and common years
      cur_req = "R5";
      do_load(24, 2, 28, 3, 23, 59, 59);
      ticks(1);
      cmp("R5", "leap feb 29", cur_day, 29);
      do_load(24, 2, 29, 4, 23, 59, 59);
      ticks(1);
      do_load(23, 2, 28, 4, 23, 59, 59);
      ticks(1);
      cmp("R5", "common feb to march", cur_mon, 3);
      do_load(0, 2, 28, 4, 23, 59, 59);
      ticks(1);

      // R6: end of century
      cur_req = "R6";
      do_load(99, 12, 31, 5, 23, 59, 59);
      ticks(1);
      cmp("R6", "year wrap", cur_year, 0);

      // R7: load together with a tick
      cur_req = "R7";
      tick_1hz = 1;
      set_load(42, 7, 4, 3, 12, 0, 30);
      cyc();
      ld_en = 0; tick_1hz = 0;
      cmp("R7", "sec after load with tick", cur_sec, 30);
      ticks(3);

      // R8: alarm subsets
      cur_req = "R8";
      set_alarm(0, 0, 0, 7, 30, 5'b00011);
      a_seen = 0;
      do_load(24, 3, 15, 2, 7, 29, 58);
      ticks(3);
      cmp("R8", "hour+minute pulses", a_seen, 1);
      a_seen = 0;
      tick_1hz = 1;
      set_load(24, 3, 15, 2, 7, 30, 0);
      cyc();
      ld_en = 0; tick_1hz = 0;
      cmp("R8", "load onto 00 pulses", a_seen, 0);
      set_alarm(0, 0, 0, 7, 30, 0);
      a_seen = 0;
      do_load(24, 3, 15, 2, 7, 29, 59);
      ticks(2);
      cmp("R8", "empty mask pulses", a_seen, 0);
      set_alarm(24, 0, 0, 0, 0, 5'b10000);
      a_seen = 0;
      do_load(24, 3, 15, 2, 10, 0, 59);
      ticks(62);
      cmp("R8", "year-only pulses", a_seen, 2);
      set_alarm(0, 0, 16, 0, 0, 5'b00100);
      a_seen = 0;
      do_load(24, 3, 15, 2, 10, 0, 59);
      ticks(2);
      cmp("R8", "day mismatch pulses", a_seen, 0);
      set_alarm(0, 0, 0, 0, 0, 0);

      // R9: one-shot timer
      cur_req = "R9";
      t_seen = 0;
      set_timer(3, 0, 1);
      ticks(10);
      cmp("R9", "one-shot pulses", t_seen, 1);

      // R10: periodic timer
      cur_req = "R10";
      t_seen = 0;
      set_timer(4, 1, 1);
      ticks(20);
      cmp("R10", "periodic pulses", t_seen, 5);

      // R11: stop and write colliding with a tick
      cur_req = "R11";
      t_seen = 0;
      set_timer(0, 1, 1);
      ticks(10);
      cmp("R11", "period 0 pulses", t_seen, 0);
      t_seen = 0;
      tick_1hz = 1;
      tmr_period = TW'(2); tmr_repeat = 1; tmr_go = 1; tmr_wr = 1;
      cyc();
      tmr_wr = 0;
      cmp("R11", "pulses in write cycle", t_seen, 0);
      repeat (2) cyc();
      tick_1hz = 0;
      cmp("R11", "pulses after tick drop", t_seen, 1);
      set_timer(5, 1, 0);
      t_seen = 0;
      ticks(12);
      cmp("R11", "run bit clear pulses", t_seen, 0);

      // random mix covering R2..R11 collisions
      cur_req = "RND";
      for (int i = 0; i < 4000; i++) begin
         tick_1hz = ($urandom % 2) == 0;
         if ($urandom % 40 == 0) begin
            int y, mo;
            y = $urandom % 100; mo = 1 + $urandom % 12;
            set_load(y, mo, 1 + $urandom % bdim(mo, y), $urandom % 7,
                     $urandom % 24, 55 + $urandom % 5, 50 + $urandom % 10);
         end else begin
            ld_en = 0;
         end
         if ($urandom % 150 == 0) begin
            alm_year = 7'(m_year); alm_mon = 4'(m_mon); alm_day = 5'(m_day);
            alm_hour = 5'(m_hour); alm_min = 6'(($urandom % 2) ? m_min : m_min + 1);
            alm_mask = 5'($urandom % 32); alm_wr = 1;
         end else begin
            alm_wr = 0;
         end
         if ($urandom % 120 == 0) begin
            tmr_period = TW'($urandom % 6); tmr_repeat = $urandom % 2;
            tmr_go = ($urandom % 4) != 0; tmr_wr = 1;
         end else begin
            tmr_wr = 0;
         end
         cyc();
      end
      tick_1hz = 0; ld_en = 0; alm_wr = 0; tmr_wr = 0;
      cyc();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule